// File: doc/BRIEF.md
# I2C Controller Command and Interrupt-Flag Register

This block is the CPU-facing control/status register of an I2C controller. It holds the interrupt request flag and sets it from event strobes that the protocol engine raises. Which events set the flag depends on the operating mode. The block also turns CPU writes of a bus-busy bit and a command-inhibit bit into one-cycle start, repeated-start and stop requests for the engine. It supplies the fixed read values of the bits that cannot be stored.

The register is 8 bits wide. Bit 7 is bus-busy (`busy`). Bit 6 is the interrupt flag. Bit 5 is the command-inhibit bit, which is write-only. Bit 4 is reserved. Bit 3 is the interrupt enable (`ien`). Bit 2 selects master mode (`mst`, 1 = master). Bit 1 is the format select (`fmt`). Bit 0 is unused.

The CPU writes with `cpu_we` and `cpu_wdata`. It reads `cpu_rdata` and strobes `cpu_re` to mark that a read was taken. The engine presents one-cycle event strobes.

Top module: `i2c_ctl_irq_reg`

## Requirements
- R1: After reset the flag, `busy`, `ien`, `mst` and `fmt` are 0, `irq` is 0, no request pulse is active, and `cpu_rdata` reads 8'h30.
- R2: With `mst`=1, a transfer-end strobe or an arbitration-lost strobe sets the flag at the next clock edge.
- R3: With `mst`=0 and `fmt`=0, the flag behaves as follows:
  - A slave-address match or a general-call match sets the flag and arms the block.
  - While the block is armed, each transfer-end strobe sets the flag.
  - A repeated-start or stop detection disarms the block.
  - A transfer-end strobe while the block is disarmed leaves the flag unchanged.
- R4: With `mst`=0 and `fmt`=1, only transfer-end strobes set the flag. Address and general-call matches have no effect.
- R5: A write with bit 6 = 0 clears the flag only if the CPU did a read (`cpu_re`) while the flag was 1 after the last write. Every write discards that read record. Writing bit 6 = 1 never changes the flag.
- R6: If a set event and a valid clear write occur in the same cycle, the flag ends at 1.
- R7: A write with bit 5 = 0 and bit 7 = 1 gives a one-cycle `start_pls` in the next cycle. `restart_pls` pulses with it if `busy` was already 1.
- R8: A write with bit 5 = 0 and bit 7 = 0 gives a one-cycle `stop_pls` in the next cycle. Only writes with bit 5 = 0 update `busy`. A write with bit 5 = 1 issues nothing and leaves `busy` unchanged.
- R9: Bits 5 and 4 always read 1 and bit 0 always reads 0, whatever was written to them.
- R10: `irq` is 1 exactly when the flag and `ien` are both 1.
- R11: `start_pls` and `stop_pls` are never active together. `restart_pls` is active only with `start_pls`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| ev_xfer_end | input | 1 | Data transfer finished |
| ev_addr_match | input | 1 | Own slave address matched |
| ev_gcall | input | 1 | General-call address seen |
| ev_arb_lost | input | 1 | Arbitration lost while transmitting |
| ev_rstart | input | 1 | Repeated start detected |
| ev_stop | input | 1 | Stop detected |
| irq | output | 1 | Interrupt request |
| start_pls | output | 1 | Start request to engine |
| restart_pls | output | 1 | Start request is a repeated start |
| stop_pls | output | 1 | Stop request to engine |

## Verification
The set logic is driven with each event strobe in each of the three modes. This separates a mode decode that is too loose from one that is too strict. In the unformatted slave mode, transfer-end strobes are placed before a match, after a match, and after a repeated start or a stop. This exposes a missing arm or disarm. Clear attempts come in several forms: without a read, after a read that another write has spoiled, with bit 6 = 1, and in the same cycle as a set event. These distinguish each qualifier of the clear rule. A long pseudo-random phase mixes all of these conditions against a behavioural model.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int DW     = 8;
    localparam int B_BUSY = 7;
    localparam int B_FLAG = 6;
    localparam int B_INH  = 5;
    localparam int B_RSV  = 4;
    localparam int B_IEN  = 3;
    localparam int B_MST  = 2;
    localparam int B_FMT  = 1;

    typedef struct packed {
        logic flag;
        logic seen;
        logic armed;
    } irq_st_t;

    typedef struct packed {
        logic busy;
        logic start;
        logic restart;
        logic stop;
    } cmd_st_t;

    typedef struct packed {
        logic ien;
        logic mst;
        logic fmt;
    } cfg_t;
endpackage

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic mst,
    input  logic fmt,
    input  logic ev_xfer_end,
    input  logic ev_addr_match,
    input  logic ev_gcall,
    input  logic ev_arb_lost,
    input  logic ev_rstart,
    input  logic ev_stop,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic wr_flag,
    output logic flag
);
    import i2c_ctl_pkg::*;

    irq_st_t st_d, st_q;
    logic    set_ev;
    logic    clr_ok;
    logic    match;

    always_comb begin
        st_d  = st_q;
        match = ev_addr_match | ev_gcall;
        if (mst) begin
            set_ev = ev_xfer_end | ev_arb_lost;
        end else if (fmt) begin
            set_ev = ev_xfer_end;
        end else begin
            set_ev = match | (st_q.armed & ev_xfer_end);
        end
        clr_ok = wr_stb & ~wr_flag & st_q.seen;

        if (set_ev) begin
            st_d.flag = 1'b1;
        end else if (clr_ok) begin
            st_d.flag = 1'b0;
        end

        if (wr_stb) begin
            st_d.seen = 1'b0;
        end else if (rd_stb && st_q.flag) begin
            st_d.seen = 1'b1;
        end

        if (ev_rstart || ev_stop) begin
            st_d.armed = 1'b0;
        end else if (match) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    a_r3_unarmed_xfer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst && !fmt && !st_q.armed && !st_q.flag && !ev_addr_match && !ev_gcall) |=> !st_q.flag);

    a_r4_fmt_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst && fmt && !ev_xfer_end && !st_q.flag) |=> !st_q.flag);
endmodule

// File: rtl/i2c_cond_cmd.sv
module i2c_cond_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_busy,
    input  logic wr_inh,
    output logic busy,
    output logic start_pls,
    output logic restart_pls,
    output logic stop_pls
);
    import i2c_ctl_pkg::*;

    cmd_st_t st_d, st_q;
    logic    cmd;

    always_comb begin
        st_d         = st_q;
        cmd          = wr_stb & ~wr_inh;
        st_d.start   = cmd & wr_busy;
        st_d.restart = cmd & wr_busy & st_q.busy;
        st_d.stop    = cmd & ~wr_busy;
        if (cmd) begin
            st_d.busy = wr_busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign start_pls   = st_q.start;
    assign restart_pls = st_q.restart;
    assign stop_pls    = st_q.stop;

    a_r11_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.start && st_q.stop));

    a_r11_restart_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.restart |-> st_q.start);

    a_r7_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.start) |-> $past(wr_stb && !wr_inh && wr_busy));

    a_r8_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stop) |-> $past(wr_stb && !wr_inh && !wr_busy));

    a_r8_inhibit_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_inh) |=> $stable(st_q.busy));
endmodule

// File: rtl/i2c_ctl_irq_reg.sv
module i2c_ctl_irq_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_we,
    input  logic       cpu_re,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       ev_xfer_end,
    input  logic       ev_addr_match,
    input  logic       ev_gcall,
    input  logic       ev_arb_lost,
    input  logic       ev_rstart,
    input  logic       ev_stop,
    output logic       irq,
    output logic       start_pls,
    output logic       restart_pls,
    output logic       stop_pls
);
    import i2c_ctl_pkg::*;

    cfg_t cfg_d, cfg_q;
    logic flag;
    logic busy;
    logic unused_wbits;

    assign unused_wbits = cpu_wdata[0] ^ cpu_wdata[B_RSV];

    always_comb begin
        cfg_d = cfg_q;
        if (cpu_we) begin
            cfg_d.ien = cpu_wdata[B_IEN];
            cfg_d.mst = cpu_wdata[B_MST];
            cfg_d.fmt = cpu_wdata[B_FMT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    i2c_irq_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .mst           (cfg_q.mst),
        .fmt           (cfg_q.fmt),
        .ev_xfer_end   (ev_xfer_end),
        .ev_addr_match (ev_addr_match),
        .ev_gcall      (ev_gcall),
        .ev_arb_lost   (ev_arb_lost),
        .ev_rstart     (ev_rstart),
        .ev_stop       (ev_stop),
        .rd_stb        (cpu_re),
        .wr_stb        (cpu_we),
        .wr_flag       (cpu_wdata[B_FLAG]),
        .flag          (flag)
    );

    i2c_cond_cmd u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (cpu_we),
        .wr_busy     (cpu_wdata[B_BUSY]),
        .wr_inh      (cpu_wdata[B_INH]),
        .busy        (busy),
        .start_pls   (start_pls),
        .restart_pls (restart_pls),
        .stop_pls    (stop_pls)
    );

    always_comb begin
        cpu_rdata         = '0;
        cpu_rdata[B_BUSY] = busy;
        cpu_rdata[B_FLAG] = flag;
        cpu_rdata[B_INH]  = 1'b1;
        cpu_rdata[B_RSV]  = 1'b1;
        cpu_rdata[B_IEN]  = cfg_q.ien;
        cpu_rdata[B_MST]  = cfg_q.mst;
        cpu_rdata[B_FMT]  = cfg_q.fmt;
    end

    assign irq = flag & cfg_q.ien;

    a_r5_clear_needs_write0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(cpu_we) && !$past(cpu_wdata[B_FLAG])));

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mst && (ev_xfer_end || ev_arb_lost)) |=> flag);

    a_r2_master_arb_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mst && ev_arb_lost) |=> cpu_rdata[B_FLAG]);
endmodule

// File: tb/i2c_ctl_irq_reg_bench.sv
`timescale 1ns/1ps
module i2c_ctl_irq_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic       cpu_re = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [5:0] ev = '0;
    logic       irq, start_pls, restart_pls, stop_pls;

    always #2.5 clk = ~clk;

    i2c_ctl_irq_reg u_i2c_ctl_irq_reg (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ev_xfer_end(ev[0]), .ev_addr_match(ev[1]), .ev_gcall(ev[2]),
        .ev_arb_lost(ev[3]), .ev_rstart(ev[4]), .ev_stop(ev[5]),
        .irq(irq), .start_pls(start_pls), .restart_pls(restart_pls), .stop_pls(stop_pls)
    );

    // behavioural reference state
    int m_flag, m_seen, m_armed, m_busy, m_ien, m_mst, m_fmt, m_start, m_rst, m_stop;
    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_seen = 0; m_armed = 0; m_busy = 0; m_ien = 0;
            m_mst = 0; m_fmt = 0; m_start = 0; m_rst = 0; m_stop = 0;
        end else begin
            int set, clr, cmd, o_flag, o_seen, o_busy;
            o_flag = m_flag; o_seen = m_seen; o_busy = m_busy;
            if (m_mst != 0) set = ev[0] | ev[3];
            else if (m_fmt != 0) set = ev[0];
            else set = ev[1] | ev[2] | (ev[0] & (m_armed != 0));
            clr = cpu_we && !cpu_wdata[6] && o_seen != 0;
            if (set != 0) m_flag = 1;
            else if (clr) m_flag = 0;
            if (cpu_we) m_seen = 0;
            else if (cpu_re && o_flag != 0) m_seen = 1;
            if (ev[4] || ev[5]) m_armed = 0;
            else if (ev[1] || ev[2]) m_armed = 1;
            cmd = cpu_we && !cpu_wdata[5];
            m_start = cmd && cpu_wdata[7];
            m_rst = cmd && cpu_wdata[7] && o_busy != 0;
            m_stop = cmd && !cpu_wdata[7];
            if (cmd != 0) m_busy = cpu_wdata[7];
            if (cpu_we) begin
                m_ien = cpu_wdata[3]; m_mst = cpu_wdata[2]; m_fmt = cpu_wdata[1];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            chk(cur_req, cpu_rdata[6], m_flag);
            chk("R9", {cpu_rdata[5:4], cpu_rdata[0]}, 3'b110);
            chk("R8", cpu_rdata[7], m_busy);
            chk("R1", {cpu_rdata[3:1]}, {m_ien[0], m_mst[0], m_fmt[0]});
            chk("R10", irq, m_flag & m_ien);
            chk("R7", start_pls, m_start);
            chk("R7", restart_pls, m_rst);
            chk("R8", stop_pls, m_stop);
            chk("R11", start_pls & stop_pls, 0);
        end
    end

    task automatic cyc(input logic we, input logic re, input logic [7:0] wd, input logic [5:0] e);
        @(negedge clk); #1;
        cpu_we = we; cpu_re = re; cpu_wdata = wd; ev = e;
        @(negedge clk); #1;
        cpu_we = 0; cpu_re = 0; ev = '0;
    endtask

    task automatic wr(input logic [7:0] d); cyc(1, 0, d, 6'd0); endtask
    task automatic rd();                    cyc(0, 1, 8'h00, 6'd0); endtask
    task automatic evt(input logic [5:0] e); cyc(0, 0, 8'h00, e); endtask

    // master, ien: 0x7C ; slave fmt0: 0x78 ; slave fmt1: 0x7A (bit5=1, no command)
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1; chk_en = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", cpu_rdata, 8'h30);
        chk("R1", irq, 0);

        cur_req = "R2";
        wr(8'h7C); evt(6'b000001); chk("R2", irq, 1);
        rd(); wr(8'h3C); chk("R5", cpu_rdata[6], 0);
        wr(8'h7C); evt(6'b001000); chk("R2", cpu_rdata[6], 1);

        cur_req = "R5";
        wr(8'h3C); chk("R5", cpu_rdata[6], 1);
        rd(); wr(8'h7C); wr(8'h3C); chk("R5", cpu_rdata[6], 1);
        rd(); wr(8'h3C); chk("R5", cpu_rdata[6], 0);

        cur_req = "R6";
        wr(8'h7C); evt(6'b000001); rd();
        cyc(1, 0, 8'h3C, 6'b000001); chk("R6", cpu_rdata[6], 1);
        rd(); wr(8'h3C);

        cur_req = "R3";
        wr(8'h78); evt(6'b000001); chk("R3", cpu_rdata[6], 0);
        evt(6'b000010); chk("R3", cpu_rdata[6], 1);
        rd(); wr(8'h38); evt(6'b000001); chk("R3", cpu_rdata[6], 1);
        rd(); wr(8'h38); evt(6'b100000); evt(6'b000001); chk("R3", cpu_rdata[6], 0);
        evt(6'b000100); chk("R3", cpu_rdata[6], 1);
        rd(); wr(8'h38); evt(6'b010000); evt(6'b000001); chk("R3", cpu_rdata[6], 0);

        cur_req = "R4";
        wr(8'h7A); evt(6'b000010); evt(6'b000100); chk("R4", cpu_rdata[6], 0);
        evt(6'b000001); chk("R4", cpu_rdata[6], 1);
        rd(); wr(8'h3A);

        cur_req = "R10";
        wr(8'h74); evt(6'b000001); chk("R10", irq, 0); chk("R10", cpu_rdata[6], 1);
        rd(); wr(8'h34);

        cur_req = "R7";
        wr(8'hDC); chk("R7", cpu_rdata[7], 1);
        wr(8'hDC);
        wr(8'hFC); chk("R8", cpu_rdata[7], 1);
        wr(8'h5C); chk("R8", cpu_rdata[7], 0);
        wr(8'hFF); chk("R9", cpu_rdata[0], 0);

        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            logic we_r, re_r;
            logic [5:0] e_r;
            we_r = ($urandom_range(0, 5) == 0);
            re_r = ($urandom_range(0, 2) == 0);
            e_r  = 6'($urandom) & 6'($urandom) & 6'($urandom);
            @(negedge clk); #1;
            cpu_we = we_r; cpu_re = re_r; cpu_wdata = 8'($urandom); ev = e_r;
        end
        @(negedge clk); #1;
        cpu_we = 0; cpu_re = 0; ev = '0;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500us;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule